// File: doc/BRIEF.md
# BCH Error-Locator Root Search

This block is a hardware accelerator for the last step of BCH decoding. It finds the roots of an error-locator polynomial Λ(x) = λ0 + λ1·x + … + λt·x^t over a binary extension field, where the field can be chosen per search as GF(2^13) or GF(2^14). Software or an upstream decoder first writes the coefficients over a small valid/ready load stream. It then pulses `start` together with the field select, the correcting capability, the number of roots it expects and the length of the codeword in bits.

The block uses a Chien-style search. One register per coefficient is stepped by a constant power of alpha on every clock, so one polynomial value Λ(α^k) is produced per cycle for k = 1, 2, 3, …. Each exponent k at which the value is zero is pushed into a 32-entry result queue and leaves the block on a valid/ready root stream. The search stops once the expected number of roots has been found or once k reaches the codeword length. At that point `irq` rises. `fail` rises with it if fewer roots than expected were found. Software maps each reported exponent to a bit position.

Back-pressure rules: a root stays on `root_pos` with `root_valid` high until `root_ready` is sampled high on a rising edge. The consumer may stall for any length of time, because the queue can hold every root a single search can produce. The load stream accepts a word only while `coef_ready` is high, and that is exactly the time when no search is running.

Top module: `bch_root_search`

## Requirements
- R1: With `gf14_sel`=0 the arithmetic is in GF(2^13) with primitive polynomial x^13+x^4+x^3+x+1. With `gf14_sel`=1 it is in GF(2^14) with x^14+x^10+x^6+x+1. A field element is a vector whose bit j is the coefficient of alpha^j, and alpha is the element 2.
- R2: A coefficient word is stored at index `coef_idx` (0..32, the index equals the power of x) when `coef_valid` and `coef_ready` are both high on a rising edge. `coef_ready` is high exactly while `busy` is low. Indices above 32 are discarded.
- R3: A search evaluates Λ(α^k) for k = 1, 2, … with one value per clock. Every k with Λ(α^k)=0 is delivered on `root_pos` in ascending order.
- R4: `cap_sel` selects the capability t as follows: 0→2, 1→4, 2→8, 3→12, 4→24, 5 to 7→32. Coefficients with index above t are treated as zero for the whole search.
- R5: The search ends as soon as `root_goal` roots have been found. `busy` falls and `irq` rises on the clock edge after the cycle that evaluated the final root, so for a last root at exponent k the end is seen k+1 cycles after the edge that accepted `start`.
- R6: If the exponent reaches `search_len` first, the search ends after evaluating k=`search_len`. `fail` is set when fewer than `root_goal` roots were found, and `irq` rises in both cases.
- R7: Roots are queued (depth 32). `root_pos` is held stable while `root_valid` is high and `root_ready` is low, and no root is lost under back-pressure.
- R8: A `start` pulse while `busy` is high has no effect on the running search or its results.
- R9: An accepted `start` clears the root queue, `irq` and `fail` on the same edge that sets `busy`.
- R10: After reset `busy`, `irq`, `fail` and `root_valid` are low, `coef_ready` is high and all coefficients are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gf14_sel | input | 1 | Field select for the next search: 0 = GF(2^13), 1 = GF(2^14) |
| cap_sel | input | 3 | Correcting-capability code, sampled with `start` |
| root_goal | input | 6 | Number of roots expected, sampled with `start` |
| search_len | input | 14 | Last exponent to evaluate, sampled with `start` |
| start | input | 1 | Begin a search when idle |
| busy | output | 1 | Search in progress |
| irq | output | 1 | Search complete; cleared by the next accepted start |
| fail | output | 1 | Fewer roots found than expected |
| coef_valid | input | 1 | Coefficient word offered |
| coef_ready | output | 1 | Coefficient word can be taken |
| coef_idx | input | 6 | Power of x for the offered coefficient |
| coef_val | input | 14 | Coefficient value (field element) |
| root_valid | output | 1 | A root exponent is presented |
| root_ready | input | 1 | Consumer takes the presented root |
| root_pos | output | 14 | Exponent k of a root α^k |

## Verification
The assertions take for granted that `root_goal` lies between 1 and the selected capability and that `search_len` is at least 1. They also take for granted that in GF(2^13) mode bit 13 of every coefficient is zero and that `root_goal` never exceeds the number of queue entries. Under these conditions the queue cannot overflow and the end-of-search flags are consistent. The stimulus builds each polynomial as a product of distinct linear factors (x + α^e) with every e below the field order, and only pairs it with goals that are no larger than the degree.

// File: rtl/chien_pkg.sv
package chien_pkg;

  localparam int GF_W = 14;

  typedef logic [GF_W-1:0] gf_t;

  // Reduction taps below the top bit for each field.
  localparam gf_t TAPS_13 = 14'h001B;
  localparam gf_t TAPS_14 = 14'h0443;

  // Multiply one element by alpha.
  function automatic gf_t gf_mul_alpha(input gf_t v, input logic f14);
    gf_t r;
    if (f14) begin
      r = {v[GF_W-2:0], 1'b0};
      if (v[GF_W-1]) r = r ^ TAPS_14;
    end else begin
      r = {v[GF_W-2:0], 1'b0};
      r[GF_W-1] = 1'b0;
      if (v[GF_W-2]) r = r ^ TAPS_13;
    end
    return r;
  endfunction

  // Multiply by alpha^p. p is a constant at every call site,
  // so this becomes a fixed XOR network per field.
  function automatic gf_t gf_mul_apow(input gf_t v, input int unsigned p,
                                      input logic f14);
    gf_t r;
    r = v;
    for (int j = 0; j < 64; j++) begin
      if (j < int'(p)) r = gf_mul_alpha(r, f14);
    end
    return r;
  endfunction

  // Capability code to maximum degree.
  function automatic logic [5:0] cap_to_t(input logic [2:0] code);
    logic [5:0] t;
    unique case (code)
      3'd0:    t = 6'd2;
      3'd1:    t = 6'd4;
      3'd2:    t = 6'd8;
      3'd3:    t = 6'd12;
      3'd4:    t = 6'd24;
      default: t = 6'd32;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/chien_coef_bank.sv
module chien_coef_bank
  import chien_pkg::*;
#(
  parameter int T_MAX = 32,
  parameter int IDX_W = $clog2(T_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  gf_t              wr_val,
  output gf_t              coef_q [T_MAX+1]
);

  generate
    for (genvar i = 0; i <= T_MAX; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          coef_q[i] <= '0;
        end else if (wr_en && (int'(wr_idx) == i)) begin
          coef_q[i] <= wr_val;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/chien_term.sv
module chien_term
  import chien_pkg::*;
#(
  parameter int IDX = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic step,
  input  logic f14,
  input  logic en,
  input  gf_t  coef_in,
  output gf_t  term_q
);

  gf_t src_w;
  gf_t nxt_w;

  assign src_w = load ? coef_in : term_q;
  assign nxt_w = gf_mul_apow(src_w, IDX, f14);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term_q <= '0;
    end else if (load) begin
      term_q <= en ? nxt_w : '0;
    end else if (step) begin
      term_q <= nxt_w;
    end
  end

endmodule

// File: rtl/chien_root_fifo.sv
module chien_root_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 14,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         full
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             pop;

  assign out_valid = (count != '0);
  assign full      = (int'(count) == DEPTH);
  assign pop       = out_valid && out_ready;
  assign out_data  = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push && !full) wr_ptr <= ptr_inc(wr_ptr);
      if (pop)           rd_ptr <= ptr_inc(rd_ptr);
      case ({push && !full, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/bch_root_search.sv
module bch_root_search
  import chien_pkg::*;
#(
  parameter int T_MAX      = 32,
  parameter int FIFO_DEPTH = 32,
  parameter int LEN_W      = 14,
  parameter int IDX_W      = $clog2(T_MAX + 1),
  parameter int CNT_W      = $clog2(T_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gf14_sel,
  input  logic [2:0]       cap_sel,
  input  logic [CNT_W-1:0] root_goal,
  input  logic [LEN_W-1:0] search_len,
  input  logic             start,
  output logic             busy,
  output logic             irq,
  output logic             fail,
  input  logic             coef_valid,
  output logic             coef_ready,
  input  logic [IDX_W-1:0] coef_idx,
  input  logic [GF_W-1:0]  coef_val,
  output logic             root_valid,
  input  logic             root_ready,
  output logic [LEN_W-1:0] root_pos
);

  // Control state
  logic             busy_q, irq_q, fail_q, fld_q;
  logic [CNT_W-1:0] goal_q, found_q, found_n;
  logic [LEN_W-1:0] len_q, k_q;

  logic       start_go, fld_w, hit_w, last_w, push_w, fifo_full_w;
  logic [5:0] t_w;
  gf_t        coef_q [T_MAX+1];
  gf_t        term_q [T_MAX+1];
  gf_t        sum_w;

  assign start_go   = start && !busy_q;
  assign fld_w      = start_go ? gf14_sel : fld_q;
  assign t_w        = cap_to_t(cap_sel);
  assign coef_ready = !busy_q;

  chien_coef_bank #(.T_MAX(T_MAX), .IDX_W(IDX_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (coef_valid && coef_ready),
    .wr_idx (coef_idx),
    .wr_val (coef_val),
    .coef_q (coef_q)
  );

  assign term_q[0] = coef_q[0];

  generate
    for (genvar i = 1; i <= T_MAX; i++) begin : g_term
      chien_term #(.IDX(i)) u_term (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start_go),
        .step    (busy_q),
        .f14     (fld_w),
        .en      (i <= int'(t_w)),
        .coef_in (coef_q[i]),
        .term_q  (term_q[i])
      );
    end
  endgenerate

  always_comb begin
    sum_w = '0;
    for (int i = 0; i <= T_MAX; i++) sum_w = sum_w ^ term_q[i];
  end

  assign hit_w   = busy_q && (sum_w == '0);
  assign push_w  = hit_w;
  assign found_n = found_q + CNT_W'(hit_w);
  assign last_w  = busy_q && ((found_n == goal_q) || (k_q == len_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      irq_q   <= 1'b0;
      fail_q  <= 1'b0;
      fld_q   <= 1'b0;
      goal_q  <= '0;
      len_q   <= '0;
      k_q     <= '0;
      found_q <= '0;
    end else if (start_go) begin
      busy_q  <= 1'b1;
      irq_q   <= 1'b0;
      fail_q  <= 1'b0;
      fld_q   <= gf14_sel;
      goal_q  <= root_goal;
      len_q   <= search_len;
      k_q     <= LEN_W'(1);
      found_q <= '0;
    end else if (busy_q) begin
      found_q <= found_n;
      k_q     <= k_q + 1'b1;
      if (last_w) begin
        busy_q <= 1'b0;
        irq_q  <= 1'b1;
        fail_q <= (found_n < goal_q);
      end
    end
  end

  chien_root_fifo #(.DEPTH(FIFO_DEPTH), .W(LEN_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (start_go),
    .push      (push_w),
    .push_data (k_q),
    .out_valid (root_valid),
    .out_ready (root_ready),
    .out_data  (root_pos),
    .full      (fifo_full_w)
  );

  assign busy = busy_q;
  assign irq  = irq_q;
  assign fail = fail_q;

endmodule

// File: rtl/bch_root_search_chk.sv
module bch_root_search_chk #(
  parameter int W = 14
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         irq,
  input logic         fail,
  input logic         coef_ready,
  input logic         root_valid,
  input logic         root_ready,
  input logic [W-1:0] root_pos,
  input logic         fifo_full,
  input logic         fifo_push
);

  p_load_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    coef_ready == !busy);

  p_irq_after_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);

  p_irq_not_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy);

  p_fail_with_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> irq);

  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (root_valid && !root_ready && !(start && !busy))
      |=> (root_valid && $stable(root_pos)));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !fifo_push);

  p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !irq) |=> (busy || irq));

  p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !irq && !fail && !root_valid));

endmodule

bind bch_root_search bch_root_search_chk #(.W(LEN_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .irq        (irq),
  .fail       (fail),
  .coef_ready (coef_ready),
  .root_valid (root_valid),
  .root_ready (root_ready),
  .root_pos   (root_pos),
  .fifo_full  (fifo_full_w),
  .fifo_push  (push_w)
);

// File: tb/bch_root_search_tb_top.sv
`timescale 1ns/1ps
module bch_root_search_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gf14_sel = 1'b0;
  logic [2:0]  cap_sel = 3'd0;
  logic [5:0]  root_goal = 6'd0;
  logic [13:0] search_len = 14'd0;
  logic        start = 1'b0;
  logic        busy, irq, fail;
  logic        coef_valid = 1'b0;
  logic        coef_ready;
  logic [5:0]  coef_idx = 6'd0;
  logic [13:0] coef_val = 14'd0;
  logic        root_valid;
  logic        root_ready = 1'b0;
  logic [13:0] root_pos;

  always #4 clk = ~clk;

  bch_root_search dut_i (
    .clk(clk), .rst_n(rst_n), .gf14_sel(gf14_sel), .cap_sel(cap_sel),
    .root_goal(root_goal), .search_len(search_len), .start(start),
    .busy(busy), .irq(irq), .fail(fail), .coef_valid(coef_valid),
    .coef_ready(coef_ready), .coef_idx(coef_idx), .coef_val(coef_val),
    .root_valid(root_valid), .root_ready(root_ready), .root_pos(root_pos)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cf[33];
  int got[64];
  int ngot;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Field model, written from R1.
  function automatic int gmul(input int a, input int b, input bit f14);
    int m = f14 ? 14 : 13;
    int poly = f14 ? 'h4443 : 'h201B;
    int r = 0;
    for (int i = 0; i < m; i++) begin
      if ((b >> i) & 1) r ^= a;
      a = a << 1;
      if ((a >> m) & 1) a ^= poly;
    end
    return r;
  endfunction

  function automatic int apow(input int e, input bit f14);
    int r = 1;
    for (int i = 0; i < e; i++) r = gmul(r, 2, f14);
    return r;
  endfunction

  // cf = product of (x + alpha^e) over the listed exponents
  task automatic build(input int e0, input int e1, input int e2, input int e3,
                       input int n, input bit f14);
    int ex[4];
    ex[0] = e0; ex[1] = e1; ex[2] = e2; ex[3] = e3;
    for (int i = 0; i < 33; i++) cf[i] = 0;
    cf[0] = 1;
    for (int j = 0; j < n; j++) begin
      int a = apow(ex[j], f14);
      for (int i = j + 1; i >= 1; i--) cf[i] = cf[i-1] ^ gmul(cf[i], a, f14);
      cf[0] = gmul(cf[0], a, f14);
    end
  endtask

  task automatic write_coef(input int idx, input int val);
    coef_valid = 1'b1;
    coef_idx   = 6'(idx);
    coef_val   = 14'(val);
    @(negedge clk);
    coef_valid = 1'b0;
  endtask

  task automatic load_all();
    for (int i = 0; i < 33; i++) write_coef(i, cf[i]);
  endtask

  task automatic kick(input bit f14, input int cap, input int goal, input int len);
    gf14_sel   = f14;
    cap_sel    = 3'(cap);
    root_goal  = 6'(goal);
    search_len = 14'(len);
    start      = 1'b1;
    ngot       = 0;
    @(negedge clk);
    start      = 1'b0;
  endtask

  // Called one negedge after the start edge; returns cycles until irq seen.
  task automatic wait_done(input int poke, output int n);
    n = 1;
    while (!irq && n < 40000) begin
      if (root_valid && root_ready) begin got[ngot] = root_pos; ngot++; end
      if (n == poke) begin
        check("R2 coef_ready low while busy", coef_ready, 0);
        start = 1'b1; coef_valid = 1'b1; coef_idx = 6'd0; coef_val = 14'd1;
      end else if (n == poke + 1) begin
        start = 1'b0; coef_valid = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0; coef_valid = 1'b0;
  endtask

  task automatic drain();
    root_ready = 1'b1;
    while (root_valid) begin
      got[ngot] = root_pos; ngot++;
      @(negedge clk);
    end
    root_ready = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 busy", busy, 0);
    check("R10 irq", irq, 0);
    check("R10 fail", fail, 0);
    check("R10 root_valid", root_valid, 0);
    check("R10 coef_ready", coef_ready, 1);
  endtask

  task automatic t_gf13_early();
    int n;
    build(5, 100, 3000, 7000, 4, 1'b0);
    load_all();
    kick(1'b0, 1, 4, 8191);
    wait_done(-5, n);
    check("R5 end cycle", n, 7001);
    check("R5 busy low", busy, 0);
    drain();
    check("R3 root count", ngot, 4);
    check("R1 R3 root0", got[0], 5);
    check("R7 root1 held", got[1], 100);
    check("R3 root2", got[2], 3000);
    check("R3 root3", got[3], 7000);
    check("R6 fail clear", fail, 0);
  endtask

  task automatic t_gf14_live();
    int n;
    build(1, 9000, 16000, 0, 3, 1'b1);
    load_all();
    root_ready = 1'b1;
    kick(1'b1, 2, 3, 16383);
    wait_done(-5, n);
    drain();
    check("R1 gf14 count", ngot, 3);
    check("R3 first exponent 1", got[0], 1);
    check("R1 gf14 root", got[1], 9000);
    check("R1 gf14 root", got[2], 16000);
    check("R5 gf14 end", n, 16001);
  endtask

  task automatic t_range_fail();
    int n;
    build(50, 4000, 0, 0, 2, 1'b0);
    load_all();
    kick(1'b0, 0, 2, 1000);
    wait_done(-5, n);
    check("R6 full range", n, 1001);
    check("R6 fail set", fail, 1);
    check("R6 irq set", irq, 1);
    drain();
    check("R6 count", ngot, 1);
    check("R6 root", got[0], 50);
  endtask

  task automatic t_cap_mask();
    int n;
    build(7, 8, 0, 0, 2, 1'b0);
    load_all();
    write_coef(3, 'h1ABC);
    write_coef(20, 'h0F0F);
    kick(1'b0, 0, 2, 100);
    wait_done(-5, n);
    drain();
    check("R4 masked count", ngot, 2);
    check("R4 masked root", got[0], 7);
    check("R4 masked root", got[1], 8);
    check("R4 no fail", fail, 0);
    // goal below degree ends early
    build(20, 30, 40, 0, 3, 1'b1);
    load_all();
    kick(1'b1, 1, 2, 200);
    wait_done(-5, n);
    drain();
    check("R5 goal two ends", n, 31);
    check("R5 goal two count", ngot, 2);
    check("R5 goal two root", got[1], 30);
  endtask

  task automatic t_busy_ignore();
    int n;
    build(300, 600, 0, 0, 2, 1'b0);
    load_all();
    kick(1'b0, 0, 2, 1000);
    wait_done(100, n);
    check("R8 end cycle", n, 601);
    drain();
    check("R8 count", ngot, 2);
    check("R8 root", got[0], 300);
    check("R2 R8 root", got[1], 600);
  endtask

  task automatic t_clear();
    int n;
    build(10, 20, 0, 0, 2, 1'b0);
    load_all();
    kick(1'b0, 0, 2, 100);
    wait_done(-5, n);
    check("R9 pending root", root_valid, 1);
    build(33, 0, 0, 0, 1, 1'b0);
    load_all();
    kick(1'b0, 0, 1, 100);
    check("R9 irq cleared", irq, 0);
    check("R9 queue cleared", root_valid, 0);
    check("R9 busy", busy, 1);
    wait_done(-5, n);
    drain();
    check("R9 count", ngot, 1);
    check("R9 root", got[0], 33);
  endtask

  initial begin
    #(190000 * 8);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gf13_early();
    t_gf14_live();
    t_range_fail();
    t_cap_mask();
    t_busy_ignore();
    t_clear();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule